// File: doc/BRIEF.md
# Transmit Echo Loopback Checker

This block watches a serial bus terminal while it transmits and confirms that the terminal hears its own words come back correctly. Each word handed to the transmitter goes into a small pending queue along with its sync type and a marker for the last word of the reply. The decoded echo of that word then arrives from the receiver with a validity flag and a sync-type flag. Every echo must be valid and must carry the sync type that was sent. Only the echo of the final word of the reply has its 16 data bits compared one by one with the word that was sent.

A separate timer watches the transmitter-busy level. If the transmitter stays busy longer than a timeout, given in nanoseconds and converted to clock cycles from the clock frequency, that also counts as a failure. All failures in a message are gathered until the message-end strobe, and the verdict is taken there. Broadcast messages are not judged at all. A failing non-broadcast message sets a pending request for the terminal-flag bit, and the status word of a later reply carries that bit. The request stays set until the terminal reports that such a status word has gone out. A configuration input can stop echo failures from raising the request, but a transmitter timeout still raises it.

Top module: `txecho_monitor`

## Requirements
- R1: A message whose broadcast indicator (`msg_bcast`, sampled with `msg_start`) was 1 is not judged: at its `msg_end`, neither `check_fail` nor `term_flag_req` changes, whatever its echoes or timer did.
- R2: Every echo (`rx_stb` while a sent word is pending) must have `rx_valid`=1 and `rx_sync` equal to the `tx_sync` of its word (1 = command/status sync, 0 = data sync). Any other echo is a failure of the message.
- R3: The 16-bit content of an echo is compared with the sent word only when that word was marked `tx_last`=1. A content difference on any other word is not a failure.
- R4: If `tx_active` stays 1 for TIMEOUT_NS*CLK_MHZ/1000 consecutive clock cycles (inclusive), the message has a transmitter timeout failure. A shorter busy stretch is not a failure.
- R5: At the `msg_end` of a non-broadcast message, `check_fail` becomes 1 on the next clock if the message had any failure. A failure also sets `term_flag_req` on that same clock.
- R6: When `cfg_flag_en`=0 at `msg_end`, echo failures (R2, R3, R8) still set `check_fail` but do not set `term_flag_req`. A timeout failure (R4) sets `term_flag_req` regardless of `cfg_flag_en`.
- R7: `status_sent`=1 clears `term_flag_req` on the next clock. If a failing non-broadcast `msg_end` falls in the same cycle, the request stays set.
- R8: A sent word whose echo has not arrived by `msg_end` is a failure. A word sent while DEPTH words are already pending (and none leaves that cycle) is dropped and counts as a failure.
- R9: A passing non-broadcast message clears `check_fail` to 0 but leaves `term_flag_req` unchanged.
- R10: After synchronous reset, `check_fail` and `term_flag_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_flag_en | input | 1 | 1: echo failures may raise the terminal-flag request |
| msg_start | input | 1 | Start-of-message strobe; clears the pending queue and the message errors |
| msg_bcast | input | 1 | Broadcast indicator, sampled with msg_start |
| msg_end | input | 1 | End-of-message strobe; takes the verdict |
| tx_stb | input | 1 | A word is handed to the transmitter |
| tx_word | input | 16 | Transmitted data bits |
| tx_sync | input | 1 | Sync type sent: 1 command/status, 0 data |
| tx_last | input | 1 | Word is the final word of the reply |
| tx_active | input | 1 | Transmitter busy level, watched by the timeout |
| rx_stb | input | 1 | Decoded word from the receiver |
| rx_word | input | 16 | Decoded data bits |
| rx_valid | input | 1 | Decoder found encoding, bit count and parity correct |
| rx_sync | input | 1 | Decoded sync type |
| status_sent | input | 1 | A status word carrying the request has been sent |
| term_flag_req | output | 1 | Pending request for the terminal-flag status bit |
| check_fail | output | 1 | Verdict of the most recent judged message |

## Verification
The main function is run with clean echoes, with a corrupted final-word echo, and with a corrupted middle-word echo. Together these show that the bit-by-bit compare is limited to the last word. Invalid echoes and echoes with the wrong sync type show that the per-word checks cover every word, and broadcast messages with bad echoes show that those messages are never judged. Busy stretches just short of and beyond the limit pin down the timeout cycle count. Runs with `cfg_flag_en` low separate the two failure kinds. Missing echoes, an overfull queue, and a status strobe that coincides with a failing verdict cover the bookkeeping edges.

// File: rtl/txecho_pkg.sv
package txecho_pkg;
  localparam int WORD_W = 16;

  // One pending transmitted word awaiting its echo
  typedef struct packed {
    logic              sync;
    logic              last;
    logic [WORD_W-1:0] word;
  } echo_rec_t;

  localparam int REC_W = $bits(echo_rec_t);
endpackage

// File: rtl/txecho_queue.sv
module txecho_queue #(
  parameter int DEPTH = 4,
  parameter int DW    = 18
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         flush,
  input  logic                         push,
  input  logic [DW-1:0]                din,
  input  logic                         pop,
  output logic [DW-1:0]                dout,
  output logic [$clog2(DEPTH+1)-1:0]   count
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    if (p == AW'(DEPTH-1)) return '0;
    return p + AW'(1);
  endfunction

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  assign dout = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      count <= count + CW'(push) - CW'(pop);
    end
  end

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    push |-> (count != CW'(DEPTH) || pop));

  no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    pop |-> (count != '0));
endmodule

// File: rtl/txecho_timer.sv
module txecho_timer #(
  parameter int LIMIT = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  output logic hit
);
  localparam int CNTW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CNTW-1:0] TOP = CNTW'(LIMIT-1);

  logic [CNTW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !active) cnt <= '0;
    else if (cnt != TOP) cnt <= cnt + CNTW'(1);
  end

  assign hit = active && (cnt == TOP);

  // R4
  idle_restart_chk: assert property (@(posedge clk) disable iff (rst)
    !active |=> (cnt == '0));
endmodule

// File: rtl/txecho_cmp.sv
module txecho_cmp
  import txecho_pkg::*;
(
  input  logic              rx_stb,
  input  logic [WORD_W-1:0] rx_word,
  input  logic              rx_valid,
  input  logic              rx_sync,
  input  echo_rec_t         head,
  input  logic              have_head,
  output logic              take,
  output logic              bad
);
  logic sync_err, data_err;

  always_comb begin
    take     = rx_stb && have_head;
    sync_err = rx_sync != head.sync;
    data_err = head.last && (rx_word != head.word);
    bad      = take && (!rx_valid || sync_err || data_err);
  end
endmodule

// File: rtl/txecho_monitor.sv
module txecho_monitor
  import txecho_pkg::*;
#(
  parameter int CLK_MHZ    = 250,
  parameter int TIMEOUT_NS = 660500,
  parameter int DEPTH      = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_flag_en,
  input  logic              msg_start,
  input  logic              msg_bcast,
  input  logic              msg_end,
  input  logic              tx_stb,
  input  logic [WORD_W-1:0] tx_word,
  input  logic              tx_sync,
  input  logic              tx_last,
  input  logic              tx_active,
  input  logic              rx_stb,
  input  logic [WORD_W-1:0] rx_word,
  input  logic              rx_valid,
  input  logic              rx_sync,
  input  logic              status_sent,
  output logic              term_flag_req,
  output logic              check_fail
);
  localparam int RAW_CYC = (CLK_MHZ * TIMEOUT_NS) / 1000;
  localparam int TO_CYC  = (RAW_CYC < 1) ? 1 : RAW_CYC;
  localparam int CW      = $clog2(DEPTH+1);

  logic [CW-1:0]    q_count, cnt_after;
  logic [REC_W-1:0] q_dout;
  echo_rec_t        head, new_rec;
  logic             take, echo_bad, push_ok, ovf, tmo_hit;
  logic             echo_err_q, tmo_err_q, bcast_q;
  logic             echo_err_n, tmo_err_n, missing_n;
  logic             end_chk, fail_n, set_flag;
  logic             flag_req_q, check_fail_q;

  assign new_rec = '{sync: tx_sync, last: tx_last, word: tx_word};
  assign head    = echo_rec_t'(q_dout);

  txecho_cmp u_cmp (
    .rx_stb    (rx_stb && !msg_start),
    .rx_word   (rx_word),
    .rx_valid  (rx_valid),
    .rx_sync   (rx_sync),
    .head      (head),
    .have_head (q_count != '0),
    .take      (take),
    .bad       (echo_bad)
  );

  always_comb begin
    push_ok   = tx_stb && !msg_start && (q_count != CW'(DEPTH) || take);
    ovf       = tx_stb && !msg_start && !push_ok;
    cnt_after = q_count + CW'(push_ok) - CW'(take);
  end

  txecho_queue #(.DEPTH(DEPTH), .DW(REC_W)) u_queue (
    .clk   (clk),
    .rst   (rst),
    .flush (msg_start),
    .push  (push_ok),
    .din   (new_rec),
    .pop   (take),
    .dout  (q_dout),
    .count (q_count)
  );

  txecho_timer #(.LIMIT(TO_CYC)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .active (tx_active),
    .hit    (tmo_hit)
  );

  always_comb begin
    echo_err_n = echo_err_q || echo_bad || ovf;
    tmo_err_n  = tmo_err_q || tmo_hit;
    missing_n  = cnt_after != '0;
    end_chk    = msg_end && !msg_start && !bcast_q;
    fail_n     = echo_err_n || missing_n || tmo_err_n;
    set_flag   = end_chk && (tmo_err_n || (cfg_flag_en && (echo_err_n || missing_n)));
  end

  // per-message error accumulation
  always_ff @(posedge clk) begin
    if (rst) begin
      echo_err_q <= 1'b0;
      tmo_err_q  <= 1'b0;
      bcast_q    <= 1'b0;
    end else if (msg_start) begin
      echo_err_q <= 1'b0;
      tmo_err_q  <= 1'b0;
      bcast_q    <= msg_bcast;
    end else begin
      echo_err_q <= echo_err_n;
      tmo_err_q  <= tmo_err_n;
    end
  end

  // verdict and pending request
  always_ff @(posedge clk) begin
    if (rst) begin
      check_fail_q <= 1'b0;
      flag_req_q   <= 1'b0;
    end else begin
      if (end_chk) check_fail_q <= fail_n;
      if (set_flag)         flag_req_q <= 1'b1;
      else if (status_sent) flag_req_q <= 1'b0;
    end
  end

  assign term_flag_req = flag_req_q;
  assign check_fail    = check_fail_q;

  // R5
  req_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_req_q) |-> $past(msg_end && !msg_start && !bcast_q));

  // R1
  bcast_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (msg_end && !msg_start && bcast_q) |=> $stable(check_fail_q));

  // R6
  tmo_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (end_chk && tmo_err_n) |=> flag_req_q);

  // R7
  clear_req_chk: assert property (@(posedge clk) disable iff (rst)
    (status_sent && !set_flag) |=> !flag_req_q);

  // R9
  pass_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (end_chk && !fail_n) |=> !check_fail_q);
endmodule

// File: tb/txecho_monitor_test.sv
module txecho_monitor_test;
  localparam int CLK_MHZ = 250;
  localparam int TMO_NS  = 200;
  localparam int DEPTH   = 4;
  localparam int TO      = CLK_MHZ * TMO_NS / 1000;

  logic clk = 0, rst = 1;
  logic cfg_flag_en = 1, msg_start = 0, msg_bcast = 0, msg_end = 0;
  logic tx_stb = 0, tx_sync = 0, tx_last = 0, tx_active = 0;
  logic [15:0] tx_word = 0, rx_word = 0;
  logic rx_stb = 0, rx_valid = 0, rx_sync = 0, status_sent = 0;
  logic term_flag_req, check_fail;

  int n_tests = 0, n_fail = 0;
  string cur_req = "R10";
  bit done = 0;

  always #2 clk = ~clk;

  txecho_monitor #(.CLK_MHZ(CLK_MHZ), .TIMEOUT_NS(TMO_NS), .DEPTH(DEPTH)) uut (.*);

  // behavioural reference model
  typedef struct { bit s; bit l; bit [15:0] w; } mrec_t;
  mrec_t mq[$];
  int  m_run;
  bit  m_echo, m_tmo, m_bc, m_req, m_fail;

  always @(posedge clk) begin
    bit setf;
    setf = 0;
    if (rst) begin
      mq.delete(); m_run = 0; m_echo = 0; m_tmo = 0; m_bc = 0; m_req = 0; m_fail = 0;
    end else begin
      m_run = tx_active ? m_run + 1 : 0;
      if (msg_start) begin
        mq.delete(); m_echo = 0; m_tmo = 0; m_bc = msg_bcast;
      end else begin
        if (rx_stb && mq.size() > 0) begin
          mrec_t r;
          r = mq.pop_front();
          if (!rx_valid || rx_sync != r.s || (r.l && rx_word != r.w)) m_echo = 1;
        end
        if (tx_stb) begin
          if (mq.size() < DEPTH) mq.push_back('{s: tx_sync, l: tx_last, w: tx_word});
          else m_echo = 1;
        end
        if (m_run >= TO) m_tmo = 1;
        if (msg_end && !m_bc) begin
          bit ef;
          ef = m_echo || (mq.size() > 0);
          m_fail = ef || m_tmo;
          setf = (ef && cfg_flag_en) || m_tmo;
        end
      end
      if (setf) m_req = 1;
      else if (status_sent) m_req = 0;
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      n_tests++;
      if (term_flag_req !== m_req || check_fail !== m_fail) begin
        n_fail++;
        $display("FAIL %s model: req=%b fail=%b expected req=%b fail=%b",
                 cur_req, term_flag_req, check_fail, m_req, m_fail);
      end
    end
  end

  task automatic chk(string tag, logic act, logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic clr();
    msg_start = 0; msg_end = 0; tx_stb = 0; rx_stb = 0; status_sent = 0;
  endtask
  task automatic t_start(bit b);
    @(negedge clk); clr(); tx_active = 0; msg_start = 1; msg_bcast = b;
  endtask
  task automatic t_tx(bit [15:0] w, bit s, bit l);
    @(negedge clk); clr(); tx_active = 1; tx_stb = 1; tx_word = w; tx_sync = s; tx_last = l;
  endtask
  task automatic t_rx(bit [15:0] w, bit v, bit s);
    @(negedge clk); clr(); tx_active = 0; rx_stb = 1; rx_word = w; rx_valid = v; rx_sync = s;
  endtask
  task automatic t_end(bit st);
    @(negedge clk); clr(); tx_active = 0; msg_end = 1; status_sent = st;
  endtask
  task automatic t_idle(int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); clr(); tx_active = 0; end
  endtask
  task automatic t_busy(int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); clr(); tx_active = 1; end
  endtask
  task automatic t_status();
    @(negedge clk); clr(); tx_active = 0; status_sent = 1;
    t_idle(1);
  endtask
  // three-word reply; e_mid / e_last are the echoed contents
  task automatic reply(bit b, bit [15:0] e_mid, bit [15:0] e_last);
    t_start(b);
    t_tx(16'h1234, 1, 0); t_rx(16'h1234, 1, 1);
    t_tx(16'hA5A5, 0, 0); t_rx(e_mid, 1, 0);
    t_tx(16'h0F0F, 0, 1); t_rx(e_last, 1, 0);
    t_end(0); t_idle(1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 reset req", term_flag_req, 0);
    chk("R10 reset fail", check_fail, 0);
    rst = 0;

    cur_req = "R9";
    reply(0, 16'hA5A5, 16'h0F0F);
    chk("R9 clean fail", check_fail, 0);
    chk("R9 clean req", term_flag_req, 0);

    cur_req = "R3";
    reply(0, 16'hA5A5, 16'h0F0E);
    chk("R3 last mismatch fail", check_fail, 1);
    chk("R5 last mismatch req", term_flag_req, 1);

    cur_req = "R7";
    t_status();
    chk("R7 status clears req", term_flag_req, 0);

    cur_req = "R3";
    reply(0, 16'hFFFF, 16'h0F0F);
    chk("R3 middle mismatch ignored", check_fail, 0);

    cur_req = "R2";
    t_start(0); t_tx(16'h1111, 1, 1); t_rx(16'h1111, 0, 1); t_end(0); t_idle(1);
    chk("R2 invalid echo", check_fail, 1);
    t_status();
    t_start(0); t_tx(16'h2222, 1, 1); t_rx(16'h2222, 1, 0); t_end(0); t_idle(1);
    chk("R2 sync mismatch", check_fail, 1);
    chk("R2 sync mismatch req", term_flag_req, 1);
    t_status();

    cur_req = "R1";
    reply(0, 16'hA5A5, 16'h0F0F);
    reply(1, 16'hA5A5, 16'h0000);
    chk("R1 broadcast fail unchanged", check_fail, 0);
    chk("R1 broadcast req unchanged", term_flag_req, 0);

    cur_req = "R6";
    cfg_flag_en = 0;
    reply(0, 16'hA5A5, 16'h0F00);
    chk("R6 disabled fail", check_fail, 1);
    chk("R6 disabled req", term_flag_req, 0);

    cur_req = "R4";
    cfg_flag_en = 1;
    t_start(0); t_busy(TO - 6); t_tx(16'h3333, 1, 1); t_rx(16'h3333, 1, 1); t_end(0); t_idle(1);
    chk("R4 short busy", check_fail, 0);
    cfg_flag_en = 0;
    t_start(0); t_busy(TO + 10); t_tx(16'h3333, 1, 1); t_rx(16'h3333, 1, 1); t_end(0); t_idle(1);
    chk("R4 timeout fail", check_fail, 1);
    chk("R6 timeout req with cfg off", term_flag_req, 1);
    cfg_flag_en = 1;
    t_status();

    cur_req = "R8";
    t_start(0); t_tx(16'h4444, 1, 0); t_rx(16'h4444, 1, 1); t_tx(16'h5555, 0, 1);
    t_end(0); t_idle(1);
    chk("R8 missing echo", check_fail, 1);
    t_status();
    t_start(0);
    for (int i = 0; i < DEPTH + 1; i++) t_tx(16'(i), 0, i == DEPTH);
    for (int i = 0; i < DEPTH + 1; i++) t_rx(16'(i), 1, 0);
    t_end(0); t_idle(1);
    chk("R8 overflow", check_fail, 1);
    t_status();

    cur_req = "R7";
    t_start(0); t_tx(16'h6666, 1, 1); t_rx(16'h6660, 1, 1); t_end(1); t_idle(1);
    chk("R7 set beats clear", term_flag_req, 1);

    cur_req = "R9";
    reply(0, 16'hA5A5, 16'h0F0F);
    chk("R9 pass clears fail", check_fail, 0);
    chk("R9 pass keeps req", term_flag_req, 1);

    t_idle(2);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule